// File: doc/BRIEF.md
# Serial Transceiver with Multidrop Address Filtering

This block is an asynchronous serial transceiver for a shared multidrop line. It sends and receives frames of either eight data bits or nine data bits. Every frame opens with a low start bit, carries its data least significant bit first, and closes with a high stop bit. In nine-bit frames an extra bit travels after the data byte and before the stop bit. The block takes a tick at sixteen times the bit rate from outside and divides it down to bit time itself. It has no baud generator of its own and no shift-register synchronous mode.

When address filtering is on and nine-bit frames are in use, a received frame raises receive-done only in two cases. The extra bit must be 1, and the byte must match either the station's own address or the broadcast address. Both patterns are built from an address word and a mask word. With filtering on and eight-bit frames in use, a frame is accepted only when its stop bit is valid. A select input decides what the top mode-bit output shows: either the frame-size mode, or a sticky frame-error flag that is set when a stop bit is sampled low.

Transmitter states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_NINTH`, `ST_STOP`. Each non-idle state lasts one bit time, sixteen ticks. The transitions are: idle to start on `tx_start`; start to data; data to ninth (nine-bit mode) or to stop after the last data bit; ninth to stop; stop to idle, which sets `tx_done`.

The receiver uses the same five states. Idle goes to start when the line is seen low on a tick. The start state goes back to idle if the majority sample at mid-bit is high, and otherwise goes on to data after one bit time. Data goes to ninth or stop after the last bit. Ninth goes to stop. Stop goes to idle at mid-bit, which ends the frame.

Top module: `mpu_serial`

## Requirements
- R1: After a `tx_start` pulse while idle, `txd` sends a 0 start bit, then the 8 bits of `tx_data` least significant first, then a 1 stop bit. Each bit lasts 16 `baud_tick` periods. `tx_done` rises at the end of the stop bit.
- R2: With `nine_bit_mode`=1, `txd` sends `tx_ninth` after the eighth data bit and before the stop bit.
- R3: An accepted frame updates `rx_data`, pulses `rx_valid` for one cycle, and sets `rx_done`. In eight-bit mode `rx_ninth` takes the received stop bit.
- R4: In nine-bit mode, `rx_ninth` takes the received ninth bit.
- R5: Each received bit is the majority of the samples at ticks 7, 8 and 9 of the bit. A start bit whose majority is 1 is dropped, and no frame is received.
- R6: With `addr_recog_en`=1 in nine-bit mode, a frame whose ninth bit is 0 is dropped. `rx_done` stays 0 and `rx_data` keeps its old value.
- R7: The own-address test passes when the received byte equals `own_addr` in every bit where `addr_mask` is 1. Example: address 0xC0 with mask 0xFD accepts 0xC0 and 0xC2 and rejects 0xC1.
- R8: The broadcast test passes when the byte has a 1 wherever (`own_addr` | `addr_mask`) has a 1. With 0xC0/0xFD this accepts 0xFF and rejects 0xFE.
- R9: With `addr_recog_en`=1 in eight-bit mode, a frame with a stop bit of 0 is dropped, and one with a stop bit of 1 is accepted.
- R10: `mode_bit` shows `nine_bit_mode` when `fe_sel`=0 and the frame-error flag when `fe_sel`=1. The flag is set by any frame whose stop bit is sampled 0 and is cleared only by `fe_clr`.
- R11: `rx_done` and `tx_done` stay set until their clear input is pulsed. A `tx_start` while a frame is being sent has no effect on the bits on `txd`.
- R12: Out of reset, `txd`=1 and `rx_done`, `tx_done`, `rx_valid` and the frame-error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| nine_bit_mode | input | 1 | 1 = nine-bit frames, 0 = eight-bit frames |
| addr_recog_en | input | 1 | Enables address / stop-bit gating of receive-done |
| fe_sel | input | 1 | 1 = `mode_bit` shows frame error |
| own_addr | input | 8 | Address word |
| addr_mask | input | 8 | Mask word (1 = bit compared) |
| tx_data | input | 8 | Byte to send |
| tx_ninth | input | 1 | Ninth bit to send |
| tx_start | input | 1 | Start-transmit strobe |
| tx_done_clr | input | 1 | Clears `tx_done` |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Last accepted byte |
| rx_ninth | output | 1 | Ninth bit, or stop bit in eight-bit mode |
| rx_valid | output | 1 | One-cycle pulse on acceptance |
| rx_done | output | 1 | Receive-done flag |
| rx_done_clr | input | 1 | Clears `rx_done` |
| fe_clr | input | 1 | Clears frame-error flag |
| tx_done | output | 1 | Transmit-done flag |
| mode_bit | output | 1 | Frame-size mode or frame error |

## Verification
The assertions assume that `baud_tick` never occurs on two back-to-back cycles. They also assume that the mode and filter inputs stay constant while a frame is in flight, and that a clear input is not pulsed in the same cycle in which the matching flag is checked for stickiness. The stimulus generates the tick from a fixed divide-by-four. It changes mode and address settings only between frames, with the line idle. It drives `rxd` only at tick boundaries, one bit per sixteen ticks.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } frame_st_t;
endpackage

// File: rtl/mpu_addr_match.sv
module mpu_addr_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic [DATA_W-1:0] addr_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic              hit_o
);
    logic [DATA_W-1:0] bcast;
    logic              own_hit, bcast_hit;

    always_comb begin
        bcast     = addr_i | mask_i;
        own_hit   = ((byte_i ^ addr_i) & mask_i) == '0;
        bcast_hit = (byte_i & bcast) == bcast;
        hit_o     = own_hit | bcast_hit;
    end
endmodule

// File: rtl/mpu_tx.sv
module mpu_tx
    import mpu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              nine_bit,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ninth_i,
    input  logic              done_clr_i,
    output logic              txd_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    frame_st_t         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              ninth_q, done_q, bit_end;

    assign bit_end = baud_tick && (cnt_q == CNT_LAST);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i) st_d = ST_START;
            ST_START: if (bit_end) st_d = ST_DATA;
            ST_DATA:  if (bit_end && idx_q == IDX_LAST) st_d = nine_bit ? ST_NINTH : ST_STOP;
            ST_NINTH: if (bit_end) st_d = ST_STOP;
            ST_STOP:  if (bit_end) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            ninth_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start_i) begin
                cnt_q   <= '0;
                idx_q   <= '0;
                shift_q <= data_i;
                ninth_q <= ninth_i;
            end else if (st_q != ST_IDLE && baud_tick) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
                if (st_q == ST_DATA && bit_end) begin
                    shift_q <= shift_q >> 1;
                    idx_q   <= idx_q + 1'b1;
                end
            end
            if (st_q == ST_STOP && bit_end) done_q <= 1'b1;
            else if (done_clr_i)            done_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_START: txd_o = 1'b0;
            ST_DATA:  txd_o = shift_q[0];
            ST_NINTH: txd_o = ninth_q;
            default:  txd_o = 1'b1;
        endcase
        done_o = done_q;
    end

    assert_done_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(st_q == ST_STOP));
    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && start_i) |=> $stable(ninth_q));
    assert_idle_line_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> txd_o);
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
    import mpu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              nine_bit,
    input  logic              rxd_i,
    output logic              end_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              ninth_o,
    output logic              stop_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] SMP_A    = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] SMP_B    = CNT_W'(OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] SMP_C    = CNT_W'(OVERSAMPLE / 2 + 1);

    frame_st_t         st_q, st_d;
    logic              rx_s1, rx_s2;
    logic [1:0]        smp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              ninth_q, stop_q, end_q;
    logic              bit_end, decide, bit_val, detect;

    always_comb begin
        bit_end = baud_tick && (cnt_q == CNT_LAST);
        decide  = baud_tick && (cnt_q == SMP_C);
        bit_val = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_s2) | (smp_q[1] & rx_s2);
        detect  = baud_tick && !rx_s2;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (detect) st_d = ST_START;
            ST_START: if (decide && bit_val) st_d = ST_IDLE;
                      else if (bit_end) st_d = ST_DATA;
            ST_DATA:  if (bit_end && idx_q == IDX_LAST) st_d = nine_bit ? ST_NINTH : ST_STOP;
            ST_NINTH: if (bit_end) st_d = ST_STOP;
            ST_STOP:  if (decide) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1   <= 1'b1;
            rx_s2   <= 1'b1;
            smp_q   <= 2'b11;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            ninth_q <= 1'b0;
            stop_q  <= 1'b1;
            end_q   <= 1'b0;
        end else begin
            rx_s1 <= rxd_i;
            rx_s2 <= rx_s1;
            end_q <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (detect) begin
                    cnt_q <= CNT_W'(1);
                    idx_q <= '0;
                end
            end else if (baud_tick) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
                if (cnt_q == SMP_A) smp_q[0] <= rx_s2;
                if (cnt_q == SMP_B) smp_q[1] <= rx_s2;
                if (decide) begin
                    unique case (st_q)
                        ST_DATA:  shift_q <= {bit_val, shift_q[DATA_W-1:1]};
                        ST_NINTH: ninth_q <= bit_val;
                        ST_STOP: begin
                            stop_q <= bit_val;
                            end_q  <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (st_q == ST_DATA && bit_end) idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        end_o   = end_q;
        byte_o  = shift_q;
        ninth_o = ninth_q;
        stop_o  = stop_q;
    end

    assert_end_returns_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |-> (st_q == ST_IDLE));
    assert_end_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |=> !end_q);
endmodule

// File: rtl/mpu_serial.sv
module mpu_serial #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              nine_bit_mode,
    input  logic              addr_recog_en,
    input  logic              fe_sel,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ninth,
    input  logic              tx_start,
    input  logic              tx_done_clr,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ninth,
    output logic              rx_valid,
    output logic              rx_done,
    input  logic              rx_done_clr,
    input  logic              fe_clr,
    output logic              tx_done,
    output logic              mode_bit
);
    logic              f_end, f_ninth, f_stop, hit, accept;
    logic [DATA_W-1:0] f_byte;
    logic              fe_q, done_q, valid_q, ninth_q;
    logic [DATA_W-1:0] data_q;

    mpu_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .nine_bit(nine_bit_mode),
        .start_i(tx_start), .data_i(tx_data), .ninth_i(tx_ninth), .done_clr_i(tx_done_clr),
        .txd_o(txd), .done_o(tx_done));

    mpu_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .nine_bit(nine_bit_mode),
        .rxd_i(rxd), .end_o(f_end), .byte_o(f_byte), .ninth_o(f_ninth), .stop_o(f_stop));

    mpu_addr_match #(.DATA_W(DATA_W)) u_match (
        .byte_i(f_byte), .addr_i(own_addr), .mask_i(addr_mask), .hit_o(hit));

    always_comb begin
        if (!addr_recog_en)     accept = 1'b1;
        else if (nine_bit_mode) accept = f_ninth && hit;
        else                    accept = f_stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q    <= 1'b0;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            ninth_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            if (f_end && !f_stop) fe_q <= 1'b1;
            else if (fe_clr)      fe_q <= 1'b0;
            if (f_end && accept) begin
                data_q  <= f_byte;
                ninth_q <= nine_bit_mode ? f_ninth : f_stop;
                valid_q <= 1'b1;
                done_q  <= 1'b1;
            end else if (rx_done_clr) begin
                done_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rx_data  = data_q;
        rx_ninth = ninth_q;
        rx_valid = valid_q;
        rx_done  = done_q;
        mode_bit = fe_sel ? fe_q : nine_bit_mode;
    end

    assert_valid_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_done);
    assert_addr_needs_ninth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && nine_bit_mode && addr_recog_en) |-> rx_ninth);
    assert_stop_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !nine_bit_mode && addr_recog_en) |-> rx_ninth);
    assert_fe_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q && !fe_clr) |=> fe_q);
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_done_clr) |=> rx_done);
endmodule

// File: tb/sim_mpu_serial.sv
module sim_mpu_serial;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic [1:0] div = 2'd0;
    logic nine_bit_mode = 1'b0, addr_recog_en = 1'b0, fe_sel = 1'b0;
    logic [7:0] own_addr = 8'h00, addr_mask = 8'h00, tx_data = 8'h00;
    logic tx_ninth = 1'b0, tx_start = 1'b0, tx_done_clr = 1'b0;
    logic rx_done_clr = 1'b0, fe_clr = 1'b0;
    logic txd, rx_ninth, rx_valid, rx_done, tx_done, mode_bit;
    logic [7:0] rx_data;
    logic drv_rxd = 1'b1, loop_en = 1'b0;
    logic rxd;
    logic [8:0] exp_q[$];
    int n_chk = 0, n_fail = 0;
    logic [7:0] last_data = 8'h00;
    bit finished = 0;

    assign rxd = loop_en ? txd : drv_rxd;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        div       <= div + 2'd1;
        baud_tick <= (div == 2'd3);
    end

    mpu_serial u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .nine_bit_mode(nine_bit_mode),
        .addr_recog_en(addr_recog_en), .fe_sel(fe_sel), .own_addr(own_addr),
        .addr_mask(addr_mask), .tx_data(tx_data), .tx_ninth(tx_ninth), .tx_start(tx_start),
        .tx_done_clr(tx_done_clr), .txd(txd), .rxd(rxd), .rx_data(rx_data),
        .rx_ninth(rx_ninth), .rx_valid(rx_valid), .rx_done(rx_done),
        .rx_done_clr(rx_done_clr), .fe_clr(fe_clr), .tx_done(tx_done), .mode_bit(mode_bit));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!baud_tick);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected frame", int'({rx_ninth, rx_data}), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({rx_ninth, rx_data} == e, "R3 scoreboard data", int'({rx_ninth, rx_data}), int'(e));
            end
        end
    end

    // drive one frame on rxd; push expectation when accepted
    task automatic send_rx(input logic [7:0] b, input logic nine, input logic nb,
                           input logic stopb, input bit acc, input string tag);
        logic [8:0] e;
        if (acc) begin
            e = {nine ? nb : stopb, b};
            exp_q.push_back(e);
        end
        wait_ticks(1);
        drv_rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            drv_rxd = b[i];
            wait_ticks(16);
        end
        if (nine) begin
            drv_rxd = nb;
            wait_ticks(16);
        end
        drv_rxd = stopb;
        wait_ticks(16);
        drv_rxd = 1'b1;
        wait_ticks(8);
        check(rx_done == acc, tag, int'(rx_done), int'(acc));
        if (acc) last_data = b;
        check(rx_data == last_data, {tag, " data"}, int'(rx_data), int'(last_data));
        pulse(rx_done_clr);
    endtask

    // transmit and sample txd at mid-bit; busy start attempt mid-frame
    task automatic send_tx(input logic [7:0] b, input logic nb, input string tag);
        logic [10:0] exp_bits;
        int nbits;
        nbits = nine_bit_mode ? 11 : 10;
        exp_bits = nine_bit_mode ? {1'b1, nb, b, 1'b0} : {1'b1, 1'b1, b, 1'b0};
        tx_data = b;
        tx_ninth = nb;
        pulse(tx_start);
        wait_ticks(8);
        for (int i = 0; i < nbits; i++) begin
            check(txd == exp_bits[i], tag, int'(txd), int'(exp_bits[i]));
            if (i == 3) begin
                tx_data = ~b;
                tx_ninth = ~nb;
                pulse(tx_start); // R11: ignored while busy
            end
            if (i < nbits - 1) wait_ticks(16);
        end
        wait_ticks(10);
        check(tx_done == 1'b1, "R1 tx_done set", int'(tx_done), 1);
        repeat (3) @(negedge clk);
        check(tx_done == 1'b1, "R11 tx_done sticky", int'(tx_done), 1);
        check(txd == 1'b1, "R11 no restart after busy start", int'(txd), 1);
        pulse(tx_done_clr);
        check(tx_done == 1'b0, "R11 tx_done cleared", int'(tx_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(txd == 1'b1, "R12 txd idle", int'(txd), 1);
        check(rx_done == 1'b0, "R12 rx_done", int'(rx_done), 0);
        check(tx_done == 1'b0, "R12 tx_done", int'(tx_done), 0);
        check(rx_valid == 1'b0, "R12 rx_valid", int'(rx_valid), 0);
        fe_sel = 1'b1;
        @(negedge clk);
        check(mode_bit == 1'b0, "R12 fe flag", int'(mode_bit), 0);
        fe_sel = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 mode_bit follows frame-size mode
        check(mode_bit == 1'b0, "R10 mode_bit eight", int'(mode_bit), 0);
        nine_bit_mode = 1'b1;
        @(negedge clk);
        check(mode_bit == 1'b1, "R10 mode_bit nine", int'(mode_bit), 1);
        nine_bit_mode = 1'b0;

        // R1 eight-bit transmit
        send_tx(8'hA5, 1'b0, "R1 txd bit");
        // R2 nine-bit transmit
        nine_bit_mode = 1'b1;
        send_tx(8'h3C, 1'b1, "R2 txd bit");
        nine_bit_mode = 1'b0;

        // R3 eight-bit receive, rx_ninth = stop
        send_rx(8'h5A, 1'b0, 1'b0, 1'b1, 1, "R3 rx_done");
        check(rx_ninth == 1'b1, "R3 rx_ninth stop", int'(rx_ninth), 1);
        // R4 nine-bit receive
        nine_bit_mode = 1'b1;
        send_rx(8'h81, 1'b1, 1'b0, 1'b1, 1, "R4 rx_done");
        check(rx_ninth == 1'b0, "R4 rx_ninth", int'(rx_ninth), 0);
        send_rx(8'h18, 1'b1, 1'b1, 1'b1, 1, "R4 rx_done ninth1");
        check(rx_ninth == 1'b1, "R4 rx_ninth one", int'(rx_ninth), 1);

        // R5 glitch start rejected
        wait_ticks(1);
        drv_rxd = 1'b0;
        wait_ticks(3);
        drv_rxd = 1'b1;
        wait_ticks(40);
        check(rx_done == 1'b0, "R5 glitch rejected", int'(rx_done), 0);
        check(rx_data == last_data, "R5 data kept", int'(rx_data), int'(last_data));

        // address filtering, nine-bit
        addr_recog_en = 1'b1;
        own_addr = 8'hC0;
        addr_mask = 8'hFD;
        send_rx(8'hC2, 1'b1, 1'b0, 1'b1, 0, "R6 ninth0 dropped");
        send_rx(8'hC2, 1'b1, 1'b1, 1'b1, 1, "R7 own C2");
        send_rx(8'hC0, 1'b1, 1'b1, 1'b1, 1, "R7 own C0");
        send_rx(8'hC1, 1'b1, 1'b1, 1'b1, 0, "R7 C1 rejected");
        send_rx(8'hFF, 1'b1, 1'b1, 1'b1, 1, "R8 broadcast FF");
        send_rx(8'hFE, 1'b1, 1'b1, 1'b1, 0, "R8 FE rejected");

        // R9 stop gating, eight-bit
        nine_bit_mode = 1'b0;
        fe_sel = 1'b1;
        @(negedge clk);
        check(mode_bit == 1'b0, "R10 fe clear before", int'(mode_bit), 0);
        send_rx(8'h77, 1'b0, 1'b0, 1'b0, 0, "R9 bad stop dropped");
        check(mode_bit == 1'b1, "R10 fe set", int'(mode_bit), 1);
        send_rx(8'h66, 1'b0, 1'b0, 1'b1, 1, "R9 good stop accepted");
        check(mode_bit == 1'b1, "R10 fe sticky", int'(mode_bit), 1);
        pulse(fe_clr);
        check(mode_bit == 1'b0, "R10 fe cleared", int'(mode_bit), 0);
        fe_sel = 1'b0;

        // loopback nine-bit with broadcast filter
        nine_bit_mode = 1'b1;
        loop_en = 1'b1;
        exp_q.push_back({1'b1, 8'hFD});
        tx_data = 8'hFD;
        tx_ninth = 1'b1;
        pulse(tx_start);
        for (int i = 0; i < 400; i++) begin
            if (rx_done) break;
            wait_ticks(1);
        end
        check(rx_done == 1'b1, "R8 loopback accepted", int'(rx_done), 1);
        check(rx_data == 8'hFD, "R2 loopback data", int'(rx_data), 8'hFD);
        pulse(rx_done_clr);
        wait_ticks(20);
        pulse(tx_done_clr);
        loop_en = 1'b0;

        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule